// File: doc/BRIEF.md
# Block Floating-Point Normalizer

The block takes a burst of up to `N` two's complement words, each marked as the start or the end of a block, and keeps them in an internal register buffer. While the words arrive it records, for each word, how many redundant sign bits it carries. The smallest of these counts belongs to the word of largest magnitude. When the block is complete, every stored word is shifted left by that one count. The largest word then has its first magnitude bit directly below the sign bit. A single shared exponent, equal to minus the shift, goes with the block.

After normalization the block waits for the consumer. While it waits, a rescale request halves every stored word with an arithmetic right shift and raises the shared exponent by one. Typically this happens when a later stage expects its arithmetic to grow. The exponent saturates at its largest positive value and raises a flag when it does. The block then streams out under a valid/ready handshake, with the final word marked. No new input is taken until the last word has left.

The controller has four states. `S_LOAD` accepts words. It moves to `S_NORM` when a word marked as the end arrives, or when the buffer is full. `S_NORM` lasts one cycle: it applies the left shift, loads the exponent, and always moves to `S_PEND`. `S_PEND` stays put while a rescale is requested. It moves to `S_EMIT` on a cycle where the consumer is ready and no rescale is requested. `S_EMIT` returns to `S_LOAD` once the final word is handed over.

Top module: `bfp_normalizer`

## Requirements
- R1: `in_ready` is high only in the loading state. It is low for the whole time a block is being output, and it is high again on the cycle after the final output word is taken.
- R2: A beat with `in_first` high starts a new block at position 0 and discards any partly received block. A beat without `in_first`, received while no block is open, is dropped and does not appear at the output.
- R3: A block closes on a beat with `in_last` high, or on its `N`-th word, whichever comes first. Its output has exactly as many words as were accepted, in arrival order, and `out_last` is high on the final one only.
- R4: The shift `s` is the smallest count of redundant sign bits over the block's words. The redundant sign bits are the bits directly below the MSB that equal the MSB, counted from the top. Each output word equals its input shifted left by `s`, and `out_exp`, a two's complement value, equals `-s`.
- R5: A block whose words are all zero is output as zeros with `s = 0` and `out_exp = 0`.
- R6: In `S_PEND`, each cycle with `ovf_req` high shifts every stored word right by one bit, replicating its sign bit, and adds one to the exponent. On that cycle `ovf_req` takes precedence over `out_ready`, and `out_valid` stays low.
- R7: A rescale request that arrives while the exponent is already at `2^(EXP_W-1)-1` leaves the exponent there and sets `exp_sat`. The words are still shifted right. `exp_sat` clears when the next block is normalized.
- R8: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_exp` hold their values. `out_exp` does not change during a block's output.
- R9: Consider the clock edge that accepts the closing word, with `out_ready` held high and no rescale requested. `out_valid` is low after that edge and after the next one, and it is high after the second edge that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts input (loading state) |
| in_data | input | W | Two's complement input word |
| in_first | input | 1 | Word opens a new block |
| in_last | input | 1 | Word closes the block |
| ovf_req | input | 1 | Rescale request: halve the stored block, exponent plus one |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | W | Normalized output word |
| out_last | output | 1 | Final word of the block |
| out_exp | output | EXP_W | Shared exponent, two's complement |
| exp_sat | output | 1 | Exponent saturated on a rescale request |

## Verification
The closing beat is taken on one edge. The left shift is applied on the next edge, where the block enters `S_PEND`. The first word becomes visible after the edge that follows, if `out_ready` is high in `S_PEND`. The R9 test samples `out_valid` at the falling edges between these three edges. Each rescale pulse changes the words and the exponent on the edge that samples it. Each output word is compared at the falling edge before the rising edge that transfers it, using the ready value just driven. `in_ready` is expected one edge after the final transfer.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

    typedef enum logic [1:0] {
        S_LOAD,
        S_NORM,
        S_PEND,
        S_EMIT
    } bfp_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_WRITE,
        OP_LSH,
        OP_RSH
    } store_op_e;

endpackage

// File: rtl/bfp_store.sv
module bfp_store
    import bfp_pkg::*;
#(
    parameter int W     = 16,
    parameter int N     = 8,
    parameter int SH_W  = 4,
    parameter int IDX_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  store_op_e           op,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic signed [W-1:0] wr_data,
    input  logic [SH_W-1:0]     lsh_amt,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic signed [W-1:0] rd_data
);

    logic signed [W-1:0] slot [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else begin
                unique case (op)
                    OP_WRITE: if (wr_idx == IDX_W'(g)) slot[g] <= wr_data;
                    OP_LSH:   slot[g] <= slot[g] <<< lsh_amt;
                    OP_RSH:   slot[g] <= slot[g] >>> 1;
                    default:  ;
                endcase
            end
        end
    end

    assign rd_data = slot[rd_idx];

endmodule

// File: rtl/bfp_peak.sv
module bfp_peak #(
    parameter int W    = 16,
    parameter int SH_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                update,
    input  logic signed [W-1:0] din,
    output logic [SH_W-1:0]     shift
);

    function automatic logic [SH_W-1:0] sign_run(input logic [W-1:0] v);
        logic [SH_W-1:0] c;
        logic            broken;
        c      = '0;
        broken = 1'b0;
        for (int i = W - 2; i >= 0; i--) begin
            if (!broken && (v[i] == v[W-1])) c = c + 1'b1;
            else broken = 1'b1;
        end
        return c;
    endfunction

    logic [SH_W-1:0] run_in;
    logic [SH_W-1:0] min_q;
    logic            nz_q;

    assign run_in = sign_run(din);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q <= '0;
            nz_q  <= 1'b0;
        end else if (start) begin
            min_q <= run_in;
            nz_q  <= |din;
        end else if (update) begin
            if (run_in < min_q) min_q <= run_in;
            nz_q <= nz_q | (|din);
        end
    end

    assign shift = nz_q ? min_q : '0;

endmodule

// File: rtl/bfp_expo.sv
module bfp_expo #(
    parameter int EXP_W = 6,
    parameter int SH_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [SH_W-1:0]         shift,
    input  logic                    inc,
    output logic signed [EXP_W-1:0] exp_o,
    output logic                    sat_o
);

    localparam logic [EXP_W-1:0] EMAX = {1'b0, {(EXP_W-1){1'b1}}};

    logic [EXP_W-1:0] exp_q;
    logic             sat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
            sat_q <= 1'b0;
        end else if (load) begin
            exp_q <= EXP_W'(0) - EXP_W'(shift);
            sat_q <= 1'b0;
        end else if (inc) begin
            if (exp_q == EMAX) sat_q <= 1'b1;
            else               exp_q <= exp_q + EXP_W'(1);
        end
    end

    assign exp_o = $signed(exp_q);
    assign sat_o = sat_q;

endmodule

// File: rtl/bfp_normalizer.sv
module bfp_normalizer
    import bfp_pkg::*;
#(
    parameter int W     = 16,
    parameter int N     = 8,
    parameter int EXP_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [W-1:0]     in_data,
    input  logic                    in_first,
    input  logic                    in_last,
    input  logic                    ovf_req,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [W-1:0]     out_data,
    output logic                    out_last,
    output logic signed [EXP_W-1:0] out_exp,
    output logic                    exp_sat
);

    localparam int SH_W  = $clog2(W);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int CNT_W = $clog2(N + 1);

    bfp_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, len_q, cnt_nx;
    logic [IDX_W-1:0] rd_q, wr_idx;
    store_op_e        st_op;
    logic             take_word, blk_done, pk_start, pk_update;
    logic             ex_load, ex_inc;
    logic [SH_W-1:0]  shift;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_LOAD;
        else        state_q <= state_d;
    end

    // next state and control outputs
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        st_op     = OP_NONE;
        wr_idx    = '0;
        take_word = 1'b0;
        blk_done  = 1'b0;
        pk_start  = 1'b0;
        pk_update = 1'b0;
        ex_load   = 1'b0;
        ex_inc    = 1'b0;
        cnt_nx    = cnt_q + CNT_W'(1);
        unique case (state_q)
            S_LOAD: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (in_first) begin
                        take_word = 1'b1;
                        pk_start  = 1'b1;
                        wr_idx    = '0;
                        cnt_nx    = CNT_W'(1);
                        blk_done  = in_last || (N == 1);
                    end else if (cnt_q != '0) begin
                        take_word = 1'b1;
                        pk_update = 1'b1;
                        wr_idx    = IDX_W'(cnt_q);
                        blk_done  = in_last || (cnt_q == CNT_W'(N - 1));
                    end
                end
                if (take_word) st_op = OP_WRITE;
                if (blk_done)  state_d = S_NORM;
            end
            S_NORM: begin
                st_op   = OP_LSH;
                ex_load = 1'b1;
                state_d = S_PEND;
            end
            S_PEND: begin
                if (ovf_req) begin
                    st_op  = OP_RSH;
                    ex_inc = 1'b1;
                end else if (out_ready) begin
                    state_d = S_EMIT;
                end
            end
            S_EMIT: begin
                out_valid = 1'b1;
                out_last  = (CNT_W'(rd_q) == len_q - CNT_W'(1));
                if (out_ready && out_last) state_d = S_LOAD;
            end
            default: state_d = S_LOAD;
        endcase
    end

    // position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= '0;
            rd_q  <= '0;
        end else begin
            if (take_word) begin
                if (blk_done) begin
                    cnt_q <= '0;
                    len_q <= cnt_nx;
                end else begin
                    cnt_q <= cnt_nx;
                end
            end
            if (state_q == S_PEND)                   rd_q <= '0;
            else if (state_q == S_EMIT && out_ready) rd_q <= rd_q + IDX_W'(1);
        end
    end

    bfp_store #(.W(W), .N(N), .SH_W(SH_W), .IDX_W(IDX_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (st_op),
        .wr_idx  (wr_idx),
        .wr_data (in_data),
        .lsh_amt (shift),
        .rd_idx  (rd_q),
        .rd_data (out_data)
    );

    bfp_peak #(.W(W), .SH_W(SH_W)) i_peak (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (pk_start),
        .update (pk_update),
        .din    (in_data),
        .shift  (shift)
    );

    bfp_expo #(.EXP_W(EXP_W), .SH_W(SH_W)) i_expo (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ex_load),
        .shift (shift),
        .inc   (ex_inc),
        .exp_o (out_exp),
        .sat_o (exp_sat)
    );

endmodule

// File: rtl/bfp_normalizer_chk.sv
module bfp_normalizer_chk #(
    parameter int W     = 16,
    parameter int EXP_W = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    ovf_req,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic signed [W-1:0]     out_data,
    input logic                    out_last,
    input logic signed [EXP_W-1:0] out_exp,
    input logic                    exp_sat
);

    localparam logic signed [EXP_W-1:0] EMAX = {1'b0, {(EXP_W-1){1'b1}}};

    p_refuse_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    p_exp_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && out_last)) |=> $stable(out_exp));

    p_sat_at_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exp_sat |-> (out_exp == EMAX));

    p_sat_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exp_sat) |-> $past(ovf_req));

    p_rescale_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_req && !out_valid && !in_ready) |=> !out_valid);

endmodule

bind bfp_normalizer bfp_normalizer_chk #(.W(W), .EXP_W(EXP_W)) i_chk (.*);

// File: tb/test_bfp_normalizer.sv
module test_bfp_normalizer;

    localparam int CLK_PERIOD = 10;
    localparam int W     = 16;
    localparam int N     = 8;
    localparam int EXP_W = 6;
    localparam int EMAX  = (1 << (EXP_W - 1)) - 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic signed [W-1:0]     in_data = '0;
    logic                    in_first = 1'b0;
    logic                    in_last = 1'b0;
    logic                    ovf_req = 1'b0;
    logic                    out_valid;
    logic                    out_ready = 1'b0;
    logic signed [W-1:0]     out_data;
    logic                    out_last;
    logic signed [EXP_W-1:0] out_exp;
    logic                    exp_sat;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic signed [W-1:0] blk [N];
    logic signed [W-1:0] ew  [N];

    bfp_normalizer #(.W(W), .N(N), .EXP_W(EXP_W)) i_bfp_normalizer (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sign_run(input logic signed [W-1:0] v);
        int c = 0;
        for (int i = W - 2; i >= 0; i--) begin
            if (v[i] != v[W-1]) break;
            c++;
        end
        return c;
    endfunction

    function automatic logic signed [W-1:0] rnd_word();
        logic signed [W-1:0] v;
        v = W'($urandom);
        return v >>> ($urandom % W);
    endfunction

    task automatic send_block(input int len, input bit use_last);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            check_eq("R1", "in_ready while loading", in_ready, 1);
            in_valid = 1'b1;
            in_data  = blk[i];
            in_first = (i == 0);
            in_last  = use_last && (i == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    // expects to be called at the falling edge after the closing word was taken
    task automatic run_out(input int len, input int novf, input bit timing);
        int  s;
        int  e;
        bit  sat;
        bit  nz;
        int  got;
        int  guard;
        bit  pend_hold;
        logic signed [W-1:0] prev;
        s = W - 1;
        nz = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (sign_run(blk[i]) < s) s = sign_run(blk[i]);
            if (blk[i] != 0) nz = 1'b1;
        end
        if (!nz) s = 0;
        e = -s;
        sat = 1'b0;
        for (int i = 0; i < len; i++) ew[i] = blk[i] <<< s;
        for (int k = 0; k < novf; k++) begin
            for (int i = 0; i < len; i++) ew[i] = ew[i] >>> 1;
            if (e == EMAX) sat = 1'b1;
            else e++;
        end
        if (timing) begin
            check_eq("R9", "out_valid one edge after close", out_valid, 0);
            @(negedge clk);
            check_eq("R9", "out_valid two edges after close", out_valid, 0);
            @(negedge clk);
            check_eq("R9", "out_valid three edges after close", out_valid, 1);
        end else begin
            out_ready = 1'b0;
            @(negedge clk);
            check_eq("R6", "out_valid while pending", out_valid, 0);
            for (int k = 0; k < novf; k++) begin
                ovf_req = 1'b1;
                out_ready = (k % 2);
                @(negedge clk);
                check_eq("R6", "out_valid during rescale", out_valid, 0);
            end
            ovf_req = 1'b0;
            out_ready = 1'b0;
        end
        got = 0;
        guard = 0;
        pend_hold = 1'b0;
        prev = '0;
        while (got < len && guard < 2000) begin
            guard++;
            if (out_valid) begin
                check_eq("R1", "in_ready during output", in_ready, 0);
                if (pend_hold) check_eq("R8", "word held under backpressure", out_data, prev);
            end
            out_ready = ($urandom % 3) != 0;
            if (out_valid && out_ready) begin
                check_eq("R4", $sformatf("word %0d", got), out_data, ew[got]);
                check_eq("R3", $sformatf("last flag word %0d", got), out_last, (got == len - 1));
                check_eq("R4", "shared exponent", out_exp, e);
                check_eq("R7", "saturation flag", exp_sat, sat);
                got++;
            end
            pend_hold = out_valid && !out_ready;
            prev = out_data;
            @(negedge clk);
        end
        check_eq("R3", "words delivered", got, len);
        out_ready = 1'b0;
        check_eq("R1", "in_ready after final word", in_ready, 1);
        check_eq("R3", "out_valid after final word", out_valid, 0);
    endtask

    initial begin
        int len;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "reset in_ready", in_ready, 1);
        check_eq("R3", "reset out_valid", out_valid, 0);
        check_eq("R7", "reset exp_sat", exp_sat, 0);

        // R9 latency with consumer ready throughout
        for (int i = 0; i < N; i++) blk[i] = W'(i * 37 - 50);
        out_ready = 1'b1;
        send_block(4, 1'b1);
        run_out(4, 0, 1'b1);

        // R5 all-zero block closed by the buffer limit (R3)
        for (int i = 0; i < N; i++) blk[i] = '0;
        send_block(N, 1'b0);
        run_out(N, 0, 1'b0);

        // most negative word: no shift
        for (int i = 0; i < N; i++) blk[i] = W'(i);
        blk[2] = {1'b1, {(W-1){1'b0}}};
        send_block(5, 1'b1);
        run_out(5, 1, 1'b0);

        // all minus one: maximum shift (R4)
        for (int i = 0; i < N; i++) blk[i] = '1;
        send_block(5, 1'b1);
        run_out(5, 0, 1'b0);

        // R2 stray beat before any first marker is dropped
        @(negedge clk);
        in_valid = 1'b1; in_first = 1'b0; in_last = 1'b1; in_data = 16'sd999;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        check_eq("R2", "stray beat leaves input open", in_ready, 1);
        for (int i = 0; i < N; i++) blk[i] = W'(100 * (i + 1));
        send_block(3, 1'b1);
        run_out(3, 0, 1'b0);

        // R2 restart discards the partial block
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_first = (i == 0); in_last = 1'b0;
            in_data = 16'sh4000;
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0;
        for (int i = 0; i < N; i++) blk[i] = W'(i - 3);
        send_block(6, 1'b1);
        run_out(6, 0, 1'b0);

        // R7 saturation on an all-zero block, then cleared on the next block
        for (int i = 0; i < N; i++) blk[i] = '0;
        send_block(2, 1'b1);
        run_out(2, EMAX + 2, 1'b0);
        for (int i = 0; i < N; i++) blk[i] = rnd_word();
        send_block(N, 1'b1);
        run_out(N, 0, 1'b0);

        // random blocks with rescale requests (R3, R4, R6)
        for (int t = 0; t < 40; t++) begin
            len = 1 + ($urandom % N);
            for (int i = 0; i < N; i++) blk[i] = rnd_word();
            send_block(len, (len < N) ? 1'b1 : ($urandom % 2 == 1));
            run_out(len, $urandom % 4, 1'b0);
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule